// File: doc/BRIEF.md
# Interrupt-Driven Transfer Request Router

This block sits between peripheral interrupt lines and the processor. Each routable source has one enable bit. With the bit clear, a raised line is passed to the processor as an ordinary interrupt. With the bit set, the line instead asks for one word transfer. The block presents that request to an external transfer engine on a request/acknowledge pair and lowers that source's remaining-transfer count. When the count runs out, the processor receives an interrupt carrying the vector of the source that asked for the transfers. The block then drops that source's enable bit, so later requests from it go to the processor.

Software reaches the block through a small register port. There are six 8-bit enable registers, and each source has a 16-bit count register. Only some bit positions are backed by a source. A separate group of fixed lines (the non-maskable interrupt, timer overflow and serial receive-error style events) can never be routed to transfer service. Addresses, source numbering and the default set of backed bits are fixed by the requirements below.

Top module: `xfr_router`

## Requirements
- R1: After reset every enable bit reads 0, `xfer_req` is low and `cpu_irq` is low.
- R2: Address k (0 to 5) holds enable register k, returned on `reg_rdata[7:0]`. Bit b of register k belongs to source 8k+b. Only backed bits can be set: register 0 = 0x11, 1 = 0x33, 2 = 0x77, 3 = 0x73, 4 = 0x66, 5 = 0x01. Other bits read 0 and ignore writes, and their sources always pass to the processor.
- R3: Address 64+s (bit 6 set, s below 48) holds the 16-bit count of source s. It can be written and read back.
- R4: A high line on an enabled source gives exactly one transfer request, with `xfer_src` = s. The request stays up until `xfer_ack`. No further transfer for s is issued until its line has gone low and high again.
- R5: Each acknowledged transfer lowers the source's count by one. A stored count of 0 means 65,536 transfers: one transfer from 0 leaves 0xFFFF and raises no interrupt.
- R6: The transfer that takes the count from 1 to 0 clears the source's enable bit and raises a processor interrupt with vector s.
- R7: A high line whose enable bit is 0 raises a processor interrupt with vector s. Fixed line f raises vector 48+f.
- R8: `cpu_irq` stays high, with `cpu_vec` unchanged, until `cpu_ack` is sampled high.
- R9: Among pending transfers, and among pass-through lines, the lowest index is served first. At most one transfer is outstanding.
- R10: A terminal-count interrupt is delivered before any waiting pass-through interrupt. No new transfer is issued while a terminal-count interrupt waits for the processor output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 7 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_src | input | 48 | Routable interrupt lines, level |
| irq_fixed | input | 4 | Lines always sent to the processor |
| xfer_req | output | 1 | Transfer request |
| xfer_src | output | 6 | Source index of the current request |
| xfer_ack | input | 1 | Transfer done acknowledge |
| cpu_irq | output | 1 | Processor interrupt valid |
| cpu_vec | output | 6 | Processor interrupt vector |
| cpu_ack | input | 1 | Processor interrupt acknowledge |

## Verification
Some properties are checked on every cycle:
- the transfer request and the processor output hold steady until they are acknowledged;
- a request drops after its acknowledge;
- each request names a backed source;
- a terminal-count clear lands on the enable bit;
- a count falls by exactly one per transfer;
- no request starts while a terminal interrupt waits.

Other behaviour only the bench scenarios can show:
- the order in which transfers and vectors come out;
- the meaning of a zero count;
- the one-transfer-per-request rule when a line is held high;
- the hand-over to pass-through once the count is exhausted.

// File: rtl/xfr_router_pkg.sv
package xfr_router_pkg;
    localparam int EN_W   = 8;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 16;
    typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/xfr_prio_pick.sv
// Lowest-index-first selector.
module xfr_prio_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/xfr_enable_bank.sv
// Enable registers with a fixed mask of backed bits and a clear vector.
module xfr_enable_bank
    import xfr_router_pkg::*;
#(
    parameter int NUM_REGS = 6,
    parameter logic [NUM_REGS*EN_W-1:0] MASK = '1,
    localparam int N = NUM_REGS * EN_W,
    localparam int RSEL_W = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RSEL_W-1:0] wr_sel,
    input  logic [EN_W-1:0]   wr_data,
    input  logic [N-1:0]      clr,
    input  logic [RSEL_W-1:0] rd_sel,
    output logic [EN_W-1:0]   rd_data,
    output logic [N-1:0]      en
);
    typedef struct packed {
        logic [N-1:0] en;
    } state_t;

    state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (wr_en && int'(wr_sel) < NUM_REGS) begin
            nxt_d.en[int'(wr_sel)*EN_W +: EN_W] = wr_data & MASK[int'(wr_sel)*EN_W +: EN_W];
        end
        nxt_d.en = nxt_d.en & ~clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_sel) < NUM_REGS) rd_data = cur_q.en[int'(rd_sel)*EN_W +: EN_W];
    end

    assign en = cur_q.en;

    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |=> ((en & $past(clr)) == '0));
endmodule

// File: rtl/xfr_count_bank.sv
// Per-source remaining-transfer counters with a register port and a decrement port.
module xfr_count_bank
    import xfr_router_pkg::*;
#(
    parameter int N = 48,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  cnt_t          wr_data,
    input  logic          dec_en,
    input  logic [IW-1:0] dec_idx,
    output cnt_t          dec_cnt,
    input  logic [IW-1:0] rd_idx,
    output cnt_t          rd_data
);
    typedef struct packed {
        logic [N-1:0][CNT_W-1:0] cnt;
    } state_t;

    state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (dec_en && int'(dec_idx) < N) nxt_d.cnt[dec_idx] = cur_q.cnt[dec_idx] - cnt_t'(1);
        if (wr_en && int'(wr_idx) < N)   nxt_d.cnt[wr_idx]  = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign dec_cnt = (int'(dec_idx) < N) ? cur_q.cnt[dec_idx] : '0;
    assign rd_data = (int'(rd_idx) < N)  ? cur_q.cnt[rd_idx]  : '0;

    p_dec_by_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && int'(dec_idx) < N && !(wr_en && wr_idx == dec_idx))
        |=> (cur_q.cnt[$past(dec_idx)] == cnt_t'($past(dec_cnt) - cnt_t'(1))));
endmodule

// File: rtl/xfr_router.sv
// Routes interrupt lines either to transfer service or to the processor.
module xfr_router
    import xfr_router_pkg::*;
#(
    parameter int NUM_EN_REGS = 6,
    parameter int NUM_FIXED   = 4,
    parameter logic [NUM_EN_REGS*EN_W-1:0] EN_MASK = 48'h01_66_73_77_33_11,
    localparam int N      = NUM_EN_REGS * EN_W,
    localparam int SRC_W  = $clog2(N),
    localparam int TOT    = N + NUM_FIXED,
    localparam int VEC_W  = $clog2(TOT),
    localparam int RSEL_W = $clog2(NUM_EN_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [N-1:0]         irq_src,
    input  logic [NUM_FIXED-1:0] irq_fixed,
    output logic                 xfer_req,
    output logic [SRC_W-1:0]     xfer_src,
    input  logic                 xfer_ack,
    output logic                 cpu_irq,
    output logic [VEC_W-1:0]     cpu_vec,
    input  logic                 cpu_ack
);
    typedef struct packed {
        logic [N-1:0]     pend;
        logic [N-1:0]     armed;
        logic             req_v;
        logic [SRC_W-1:0] req_idx;
        logic             tc_v;
        logic [VEC_W-1:0] tc_vec;
        logic             out_v;
        logic [VEC_W-1:0] out_vec;
    } state_t;

    state_t cur_q, nxt_d;

    // register decode
    logic [5:0] addr_lo;
    logic       en_hit, cnt_hit;
    assign addr_lo = reg_addr[5:0];
    assign en_hit  = !reg_addr[6] && (int'(addr_lo) < NUM_EN_REGS);
    assign cnt_hit = reg_addr[6] && (int'(addr_lo) < N);

    logic [N-1:0]    en, clr_vec;
    logic [EN_W-1:0] en_rd;
    cnt_t            cnt_rd, dec_cnt;
    logic            ack_fire, tc_now;

    assign ack_fire = cur_q.req_v && xfer_ack;
    assign tc_now   = ack_fire && (dec_cnt == cnt_t'(1));

    always_comb begin
        clr_vec = '0;
        if (tc_now) clr_vec[cur_q.req_idx] = 1'b1;
    end

    xfr_enable_bank #(.NUM_REGS(NUM_EN_REGS), .MASK(EN_MASK)) u_en (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr && en_hit), .wr_sel(addr_lo[RSEL_W-1:0]),
        .wr_data(reg_wdata[EN_W-1:0]), .clr(clr_vec),
        .rd_sel(addr_lo[RSEL_W-1:0]), .rd_data(en_rd), .en(en)
    );

    xfr_count_bank #(.N(N)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr && cnt_hit), .wr_idx(addr_lo[SRC_W-1:0]), .wr_data(reg_wdata),
        .dec_en(ack_fire), .dec_idx(cur_q.req_idx), .dec_cnt(dec_cnt),
        .rd_idx(addr_lo[SRC_W-1:0]), .rd_data(cnt_rd)
    );

    always_comb begin
        reg_rdata = '0;
        if (en_hit)       reg_rdata = {{(DATA_W-EN_W){1'b0}}, en_rd};
        else if (cnt_hit) reg_rdata = cnt_rd;
    end

    // selectors
    logic             tx_any, pt_any;
    logic [SRC_W-1:0] tx_idx;
    logic [VEC_W-1:0] pt_idx;

    xfr_prio_pick #(.N(N), .IW(SRC_W)) u_tx_pick (
        .req(cur_q.pend & en), .any(tx_any), .idx(tx_idx)
    );
    xfr_prio_pick #(.N(TOT), .IW(VEC_W)) u_pt_pick (
        .req({irq_fixed, irq_src & ~en}), .any(pt_any), .idx(pt_idx)
    );

    always_comb begin
        nxt_d = cur_q;
        // re-arm a source once its line is seen low
        nxt_d.armed = cur_q.armed | ~irq_src;
        if (ack_fire) nxt_d.armed[cur_q.req_idx] = 1'b0;
        nxt_d.pend = (cur_q.pend | (irq_src & nxt_d.armed)) & en;
        if (ack_fire) begin
            nxt_d.pend[cur_q.req_idx] = 1'b0;
            nxt_d.req_v = 1'b0;
        end
        // launch one transfer at a time, never while a terminal interrupt waits
        if (!cur_q.req_v && !cur_q.tc_v && tx_any) begin
            nxt_d.req_v   = 1'b1;
            nxt_d.req_idx = tx_idx;
        end
        // processor output slot
        if (cur_q.out_v && cpu_ack) nxt_d.out_v = 1'b0;
        if (!cur_q.out_v) begin
            if (cur_q.tc_v) begin
                nxt_d.out_v   = 1'b1;
                nxt_d.out_vec = cur_q.tc_vec;
                nxt_d.tc_v    = 1'b0;
            end else if (tc_now) begin
                nxt_d.out_v   = 1'b1;
                nxt_d.out_vec = VEC_W'(cur_q.req_idx);
            end else if (pt_any) begin
                nxt_d.out_v   = 1'b1;
                nxt_d.out_vec = pt_idx;
            end
        end else if (tc_now) begin
            nxt_d.tc_v   = 1'b1;
            nxt_d.tc_vec = VEC_W'(cur_q.req_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.armed <= '1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign xfer_req = cur_q.req_v;
    assign xfer_src = cur_q.req_idx;
    assign cpu_irq  = cur_q.out_v;
    assign cpu_vec  = cur_q.out_vec;

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_src)));
    p_single_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack) |=> !xfer_req);
    p_cpu_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && !cpu_ack) |=> (cpu_irq && $stable(cpu_vec)));
    p_no_launch_waiting_tc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_req) |-> !$past(cur_q.tc_v));
    p_backed_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> EN_MASK[xfer_src]);
endmodule

// File: tb/xfr_router_test.sv
`timescale 1ns/1ps
module xfr_router_test;
    localparam int N = 48;
    localparam int F = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [N-1:0] irq_src = '0;
    logic [F-1:0] irq_fixed = '0;
    logic        xfer_req;
    logic [5:0]  xfer_src;
    logic        xfer_ack = 1'b0;
    logic        cpu_irq;
    logic [5:0]  cpu_vec;
    logic        cpu_ack = 1'b0;

    int total = 0;
    int bad = 0;
    int exp_xfer[$];
    int exp_cpu[$];
    bit keep_line = 1'b0;
    bit cpu_hold = 1'b0;
    int rd;
    int xs, xe, cv, ce;

    xfr_router uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_src(irq_src),
        .irq_fixed(irq_fixed), .xfer_req(xfer_req), .xfer_src(xfer_src),
        .xfer_ack(xfer_ack), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec), .cpu_ack(cpu_ack)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input int a, input int d);
        @(negedge clk);
        reg_addr = 7'(a); reg_wdata = 16'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output int d);
        @(negedge clk);
        reg_addr = 7'(a);
        #1 d = int'(reg_rdata);
    endtask

    task automatic drain();
        int k = 0;
        while ((exp_xfer.size() != 0 || exp_cpu.size() != 0 || xfer_req || cpu_irq) && k < 3000) begin
            @(negedge clk);
            k++;
        end
        repeat (4) @(negedge clk);
        if (k >= 3000) check(1'b0, "drain timeout", k, 0);
    endtask

    // transfer engine model: compares, acknowledges, clears the peripheral line
    always begin
        @(negedge clk);
        if (xfer_req) begin
            xs = int'(xfer_src);
            if (exp_xfer.size() == 0) check(1'b0, "R4 unexpected transfer", xs, -1);
            else begin
                xe = exp_xfer.pop_front();
                check(xs == xe, "R9 transfer source order", xs, xe);
            end
            repeat (2) @(negedge clk);
            xfer_ack = 1'b1;
            if (!keep_line) irq_src[xs] = 1'b0;
            @(negedge clk);
            xfer_ack = 1'b0;
        end
    end

    // processor model: compares vector, acknowledges, clears the line
    always begin
        @(negedge clk);
        if (cpu_irq && !cpu_hold) begin
            cv = int'(cpu_vec);
            if (exp_cpu.size() == 0) check(1'b0, "R7 unexpected cpu vector", cv, -1);
            else begin
                ce = exp_cpu.pop_front();
                check(cv == ce, "R7 cpu vector order", cv, ce);
            end
            cpu_ack = 1'b1;
            if (cv < N) irq_src[cv] = 1'b0;
            else        irq_fixed[cv-N] = 1'b0;
            @(negedge clk);
            cpu_ack = 1'b0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int mask_b[6] = '{8'h11, 8'h33, 8'h77, 8'h73, 8'h66, 8'h01};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(xfer_req == 1'b0, "R1 xfer_req after reset", xfer_req, 0);
        check(cpu_irq == 1'b0, "R1 cpu_irq after reset", cpu_irq, 0);
        for (int k = 0; k < 6; k++) begin
            reg_read(k, rd);
            check(rd == 0, "R1 enable reset value", rd, 0);
        end
        // R2 backed-bit mask
        for (int k = 0; k < 6; k++) begin
            reg_write(k, 16'hFFFF);
            reg_read(k, rd);
            check(rd == mask_b[k], "R2 enable mask readback", rd, mask_b[k]);
            reg_write(k, 0);
        end
        // R3 count register access
        reg_write(64 + 30, 16'hA5C3);
        reg_read(64 + 30, rd);
        check(rd == 16'hA5C3, "R3 count readback", rd, 16'hA5C3);

        // R7 pass-through: disabled source, unbacked bit, fixed line
        reg_write(0, 16'h00FF);
        exp_cpu.push_back(1);
        irq_src[1] = 1'b1;
        drain();
        reg_write(0, 0);
        exp_cpu.push_back(4);
        irq_src[4] = 1'b1;
        drain();
        exp_cpu.push_back(N + 2);
        irq_fixed[2] = 1'b1;
        drain();

        // R4 R5 R6 count of three on source 0
        reg_write(64 + 0, 3);
        reg_write(0, 16'h0001);
        for (int t = 0; t < 3; t++) begin
            exp_xfer.push_back(0);
            if (t == 2) exp_cpu.push_back(0);
            irq_src[0] = 1'b1;
            drain();
            if (t == 1) begin
                reg_read(64 + 0, rd);
                check(rd == 1, "R5 count after two transfers", rd, 1);
            end
        end
        reg_read(64 + 0, rd);
        check(rd == 0, "R6 count exhausted", rd, 0);
        reg_read(0, rd);
        check(rd == 0, "R6 enable cleared at terminal count", rd, 0);
        exp_cpu.push_back(0);
        irq_src[0] = 1'b1;
        drain();

        // R4 held line yields one transfer
        reg_write(64 + 4, 5);
        reg_write(0, 16'h0010);
        keep_line = 1'b1;
        exp_xfer.push_back(4);
        irq_src[4] = 1'b1;
        drain();
        repeat (20) @(negedge clk);
        check(xfer_req == 1'b0, "R4 no repeat while line held", xfer_req, 0);
        reg_read(64 + 4, rd);
        check(rd == 4, "R4 single decrement for held line", rd, 4);
        irq_src[4] = 1'b0;
        repeat (2) @(negedge clk);
        keep_line = 1'b0;
        exp_xfer.push_back(4);
        irq_src[4] = 1'b1;
        drain();
        reg_read(64 + 4, rd);
        check(rd == 3, "R4 second request second transfer", rd, 3);
        reg_write(0, 0);

        // R9 fixed priority, transfers and pass-through
        reg_write(64 + 8, 10);
        reg_write(64 + 9, 10);
        reg_write(64 + 12, 10);
        reg_write(1, 16'h0013);
        exp_xfer.push_back(8); exp_xfer.push_back(9); exp_xfer.push_back(12);
        @(negedge clk);
        irq_src[12] = 1'b1; irq_src[9] = 1'b1; irq_src[8] = 1'b1;
        drain();
        exp_cpu.push_back(13); exp_cpu.push_back(N + 3);
        @(negedge clk);
        irq_fixed[3] = 1'b1; irq_src[13] = 1'b1;
        drain();
        reg_write(1, 0);

        // R5 stored zero means 65,536
        reg_write(64 + 16, 0);
        reg_write(2, 16'h0001);
        exp_xfer.push_back(16);
        irq_src[16] = 1'b1;
        drain();
        reg_read(64 + 16, rd);
        check(rd == 16'hFFFF, "R5 zero count wraps to FFFF", rd, 16'hFFFF);
        check(cpu_irq == 1'b0, "R5 no interrupt from zero count", cpu_irq, 0);
        reg_read(2, rd);
        check(rd == 1, "R5 enable kept after zero-count transfer", rd, 1);

        // R10 terminal count ahead of pass-through, launches held off
        reg_write(64 + 17, 1);
        reg_write(64 + 20, 5);
        reg_write(2, 16'h0012);
        cpu_hold = 1'b1;
        exp_cpu.push_back(N + 0);
        irq_fixed[0] = 1'b1;
        repeat (4) @(negedge clk);
        exp_xfer.push_back(17);
        irq_src[17] = 1'b1;
        repeat (10) @(negedge clk);
        check(xfer_req == 1'b0 && exp_xfer.size() == 0, "R10 terminal transfer done", xfer_req, 0);
        exp_cpu.push_back(17); exp_cpu.push_back(N + 1);
        irq_fixed[1] = 1'b1;
        exp_xfer.push_back(20);
        irq_src[20] = 1'b1;
        repeat (10) @(negedge clk);
        check(xfer_req == 1'b0, "R10 no launch while terminal interrupt waits", xfer_req, 0);
        check(cpu_irq == 1'b1 && cpu_vec == 6'(N), "R8 slot held without ack", cpu_vec, N);
        cpu_hold = 1'b0;
        drain();
        reg_read(2, rd);
        check(rd == 16'h10, "R6 only terminal source disabled", rd, 16'h10);
        check(exp_xfer.size() == 0 && exp_cpu.size() == 0, "R9 all expected items seen",
              exp_xfer.size() + exp_cpu.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule